// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block turns a single-beat write request into the strobe waveform that an asynchronous static RAM needs to store one word. A requester presents an address and a data word with `req_valid`. The block takes the request when `req_ready` is high, which happens only while it is idle. It then drives the memory address, the active-low chip-select and write strobes, and an enable for the data drivers. It releases the bus only after the whole write cycle and the recovery time have run out. Every timing value is a nanosecond parameter. Each one becomes a whole number of clock cycles through ceiling division by the clock period parameter, so every phase lasts at least its nanosecond minimum.

The memory stores the word while both strobes are low. The store starts at the later of the two falling edges and ends at the earlier of the two rising edges. A per-request select input, `term_sel`, chooses which strobe ends the store. With `term_sel` = 0 the write strobe ends it: chip-select falls first, and the write strobe falls and rises inside the chip-select window. With `term_sel` = 1 chip-select ends it: the write strobe falls first, and chip-select is the first strobe to rise. The data drivers turn on only after the memory's output turn-off delay has passed, which avoids contention on the shared data pins.

Back-pressure: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the request inputs are ignored and may change freely. A requester that holds `req_valid` high is served on the first idle cycle, so requests can follow one another back to back.

Top module: `sram_wr_seq`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `mem_ce_n` and `mem_we_n` are 1, and `mem_dq_oe` is 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until recovery ends. Request inputs seen while `req_ready` is 0, or while `req_valid` is 0, change nothing at the memory side. While `req_ready` is 1, both strobes are high and the data drivers are off.
- R3: From the cycle after acceptance, `mem_addr` equals the accepted address. `mem_addr` changes only on an edge where both strobes are high before and after that edge.
- R4: After acceptance, both strobes stay high for SET = max(1, ceil(T_AS/CLK)) cycles. Then one strobe alone goes low for one cycle: chip-select when `term_sel` was 0, the write strobe when it was 1.
- R5: Both strobes are then low together for OVL cycles. OVL = max(ceil(T_WP/CLK), ceil(T_CW/CLK), ceil(T_AW/CLK) − SET, ceil(T_WZ/CLK) + max(1, ceil(T_DW/CLK))).
- R6: The store ends with one strobe rising alone: the write strobe when `term_sel` was 0, chip-select when it was 1. The other strobe stays low for exactly one more cycle.
- R7: `mem_dq_oe` is 1 only during the both-low window, from overlap cycle ceil(T_WZ/CLK) (counting from 0) through the last overlap cycle. While it is 1, `mem_dq` equals the accepted data and does not change.
- R8: After both strobes are high again, they stay high for REC cycles. REC = max(1, ceil(T_WR/CLK), ceil(T_WC/CLK) − (SET + OVL + 2)), where T_WR is T_WR_WE_NS for `term_sel` = 0 and T_WR_CE_NS for `term_sel` = 1. `req_ready` returns to 1 in the cycle after that.
- R9: A request held valid across a busy period is accepted on the first cycle `req_ready` is 1, and its cycle starts at once with no overlap with the previous one. `term_sel` is latched at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | AW | Request address |
| req_data | input | DW | Request data word |
| term_sel | input | 1 | 0: write strobe ends the store, 1: chip-select ends it |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Memory chip-select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq | output | DW | Data to memory pins |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The bench sweeps every address of a small configuration in both end modes. It keeps `req_valid` high the whole time and changes the address, data and mode right after each acceptance. A design that latched late would move `mem_addr` in the middle of a store or switch its ending strobe partway through. Every cycle of every transaction is compared with a phase table the bench computes from the nanosecond parameters. An off-by-one in any counter shows up as a strobe edge one cycle early or late. The bench also catches a data enable that turns on before the turn-off delay has passed, and a recovery time taken from the wrong mode, which would return `req_ready` too early when chip-select ends the store.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LEAD,
    PH_OVL,
    PH_TAIL,
    PH_RECOV
  } wr_phase_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_phase_ctr.sv
module sram_wr_phase_ctr
  import sram_wr_pkg::*;
#(
  parameter int SET_CYC = 1,
  parameter int OVL_CYC = 7,
  parameter int REC_WE  = 1,
  parameter int REC_CE  = 2,
  parameter int WZ_CYC  = 3,
  parameter int CNT_W   = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      ce_term_in,
  output wr_phase_e phase,
  output logic      ce_term,
  output logic      drive_win
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rec_last;

  assign rec_last  = ce_term ? CNT_W'(REC_CE - 1) : CNT_W'(REC_WE - 1);
  assign drive_win = (phase == PH_OVL) && (cnt >= CNT_W'(WZ_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      ce_term <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_SETUP;
            cnt     <= '0;
            ce_term <= ce_term_in;
          end
        end
        PH_SETUP: begin
          if (cnt == CNT_W'(SET_CYC - 1)) begin
            phase <= PH_LEAD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_LEAD: begin
          phase <= PH_OVL;
          cnt   <= '0;
        end
        PH_OVL: begin
          if (cnt == CNT_W'(OVL_CYC - 1)) begin
            phase <= PH_TAIL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_TAIL: begin
          phase <= PH_RECOV;
          cnt   <= '0;
        end
        PH_RECOV: begin
          if (cnt == rec_last) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_wr_strobe_dec.sv
module sram_wr_strobe_dec
  import sram_wr_pkg::*;
(
  input  wr_phase_e phase,
  input  logic      ce_term,
  input  logic      drive_win,
  output logic      ce_n,
  output logic      we_n,
  output logic      dq_oe
);

  logic ce_low, we_low;

  always_comb begin
    ce_low = 1'b0;
    we_low = 1'b0;
    unique case (phase)
      // lead and tail share one shape: only the non-terminating strobe is low
      PH_LEAD, PH_TAIL: begin
        ce_low = !ce_term;
        we_low = ce_term;
      end
      PH_OVL: begin
        ce_low = 1'b1;
        we_low = 1'b1;
      end
      default: begin
        ce_low = 1'b0;
        we_low = 1'b0;
      end
    endcase
  end

  assign ce_n  = !ce_low;
  assign we_n  = !we_low;
  assign dq_oe = drive_win;

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int CLK_NS     = 10,
  parameter int T_WC_NS    = 70,
  parameter int T_CW_NS    = 65,
  parameter int T_AW_NS    = 65,
  parameter int T_AS_NS    = 0,
  parameter int T_WP_NS    = 55,
  parameter int T_DW_NS    = 30,
  parameter int T_WR_WE_NS = 5,
  parameter int T_WR_CE_NS = 15,
  parameter int T_WZ_NS    = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          term_sel,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq,
  output logic          mem_dq_oe
);

  localparam int SET_CYC = imax(1, ns2cyc(T_AS_NS, CLK_NS));
  localparam int WZ_CYC  = ns2cyc(T_WZ_NS, CLK_NS);
  localparam int OVL_CYC = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS)),
                                imax(ns2cyc(T_AW_NS, CLK_NS) - SET_CYC,
                                     WZ_CYC + imax(1, ns2cyc(T_DW_NS, CLK_NS))));
  localparam int FIX_CYC = SET_CYC + OVL_CYC + 2;
  localparam int WC_REST = ns2cyc(T_WC_NS, CLK_NS) - FIX_CYC;
  localparam int REC_WE  = imax(imax(1, ns2cyc(T_WR_WE_NS, CLK_NS)), WC_REST);
  localparam int REC_CE  = imax(imax(1, ns2cyc(T_WR_CE_NS, CLK_NS)), WC_REST);
  localparam int MAX_CNT = imax(imax(SET_CYC, OVL_CYC), imax(REC_WE, REC_CE));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  wr_phase_e     phase;
  logic          ce_term;
  logic          drive_win;
  logic          accept;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  sram_wr_phase_ctr #(
    .SET_CYC(SET_CYC),
    .OVL_CYC(OVL_CYC),
    .REC_WE (REC_WE),
    .REC_CE (REC_CE),
    .WZ_CYC (WZ_CYC),
    .CNT_W  (CNT_W)
  ) phase_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .ce_term_in(term_sel),
    .phase     (phase),
    .ce_term   (ce_term),
    .drive_win (drive_win)
  );

  sram_wr_strobe_dec dec_i (
    .phase    (phase),
    .ce_term  (ce_term),
    .drive_win(drive_win),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .dq_oe    (mem_dq_oe)
  );

  assign mem_addr = addr_q;
  assign mem_dq   = data_q;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq,
  input logic          mem_dq_oe
);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n)));

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

  assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(mem_ce_n) && $fell(mem_we_n)));

  assert_single_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(mem_ce_n) && $rose(mem_we_n)));

  assert_drive_in_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n));

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_dq   (mem_dq),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb_top;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CLK = 4;
  localparam int NTX = 2 * (1 << AW);

  function automatic int cy(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths from the requirement formulas (default ns values)
  localparam int E_SET = mx(1, cy(0));
  localparam int E_WZ  = cy(25);
  localparam int E_OVL = mx(mx(cy(55), cy(65)), mx(cy(65) - E_SET, E_WZ + mx(1, cy(30))));
  localparam int E_RWE = mx(mx(1, cy(5)),  cy(70) - (E_SET + E_OVL + 2));
  localparam int E_RCE = mx(mx(1, cy(15)), cy(70) - (E_SET + E_OVL + 2));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          term_sel = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .CLK_NS(CLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .term_sel(term_sel),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
  );

  function automatic logic [AW-1:0] tx_addr(input int i);
    return AW'((i / 2) * 5 + 3);
  endfunction
  function automatic logic [DW-1:0] tx_data(input int i);
    return DW'(i * 37 + 11);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_req(input int i);
    if (i < NTX) begin
      req_valid = 1'b1;
      req_addr  = tx_addr(i);
      req_data  = tx_data(i);
      term_sel  = i[0];
    end else begin
      req_valid = 1'b0;
      req_addr  = '1;
      req_data  = '1;
      term_sel  = 1'b0;
    end
  endtask

  // caller stands at a negedge with req_ready high and request i driven
  task automatic run_txn(input int i);
    bit mode = i[0];
    int rec = mode ? E_RCE : E_RWE;
    int tot = E_SET + E_OVL + 2 + rec;
    @(posedge clk);
    for (int k = 0; k <= tot; k++) begin
      logic rdy, ce, we, oe;
      string tag;
      @(negedge clk);
      rdy = 0; ce = 1; we = 1; oe = 0;
      if (k < E_SET) begin
        tag = "R4 setup";
      end else if (k == E_SET) begin
        tag = "R4 lead"; ce = mode; we = !mode;
      end else if (k < E_SET + 1 + E_OVL) begin
        tag = "R5/R7 overlap"; ce = 0; we = 0; oe = (k - E_SET - 1) >= E_WZ;
      end else if (k == E_SET + 1 + E_OVL) begin
        tag = "R6 tail"; ce = mode; we = !mode;
      end else if (k < tot) begin
        tag = "R8 recovery";
      end else begin
        tag = "R8 ready return"; rdy = 1;
      end
      check(tag, {28'd0, req_ready, mem_ce_n, mem_we_n, mem_dq_oe}, {28'd0, rdy, ce, we, oe});
      check((i > 0 && k == 0) ? "R9 back-to-back addr" : "R2/R3 addr held",
            32'(mem_addr), 32'(tx_addr(i)));
      if (oe) check("R7 data", 32'(mem_dq), 32'(tx_data(i)));
      if (k == 0) drive_req(i + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {29'd0, req_ready, mem_ce_n, mem_we_n}, 32'h7);
    check("R1 reset oe", 32'(mem_dq_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {28'd0, req_ready, mem_ce_n, mem_we_n, mem_dq_oe}, 32'hE);
    // inputs wiggle with valid low: nothing may reach the memory side
    req_addr = 4'hA; req_data = 8'h5C; term_sel = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R2 idle no accept", {28'd0, req_ready, mem_ce_n, mem_we_n, mem_dq_oe}, 32'hE);
      check("R2 idle addr", 32'(mem_addr), 32'd0);
    end
    drive_req(0);
    for (int i = 0; i < NTX; i++) run_txn(i);
    repeat (3) begin
      @(negedge clk);
      check("R2 quiet after last", {28'd0, req_ready, mem_ce_n, mem_we_n, mem_dq_oe}, 32'hE);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule